// File: doc/BRIEF.md
# Processor-Local Countdown Timer

This block is a per-core countdown timer driven through a small register port. Software first sets a control word, which holds an interrupt vector, a mask flag and a run mode. It then picks a clock prescale through a 4-bit code and writes a start value. Writing the start value loads the counter and restarts the prescaler. From then on the counter steps down once per prescaled tick.

The current value can be read back at any time, so software can compute elapsed ticks as the start value minus the current value. When the count steps from one to zero, the block raises an interrupt request that carries the vector. A set mask flag suppresses that request. The request is held until the acknowledge input is pulsed. While the request is held, a read-only status bit in the control word reads 1.

In one-shot mode the counter halts at zero. In periodic mode the counter reloads the start value on the tick that follows zero, so one period is (start + 1) prescaled ticks. The other two mode codes leave the counter frozen.

Top module: `cpu_tick_timer`

## Requirements
- R1: After synchronous reset, irq_req is 0 and the control, start-value and current-count registers read 0.
- R2: Writing the start register (addr 1) loads the current count (addr 2, read-only). Each prescaled tick lowers it by one while the count is nonzero, in mode 0 or 1.
- R3: With divisor D and start value N, irq_req rises exactly N*D clock edges after the edge that accepts the start write. irq_vector then equals control bits 7:0.
- R4: The prescale register (addr 3, bits 3:0) selects the divisor: 1011 gives 1; 0000, 0001, 0010 and 0011 give 2, 4, 8 and 16; 1000, 1001 and 1010 give 32, 64 and 128.
- R5: A prescale code not listed in R4 (any code with bit 2 set, other than 1011) divides by 1.
- R6: In one-shot mode (control bits 18:17 = 00), the count stays at 0 after expiry and no further request is raised.
- R7: In periodic mode (bits 18:17 = 01), the count reloads the start value on the tick after reaching zero. Requests then repeat every (N+1)*D edges.
- R8: When control bit 16 (mask) is 1, an expiry raises no request and leaves the status bit at 0.
- R9: Control bit 12 reads 1 while a request is pending and 0 otherwise. Software writes to that bit have no effect.
- R10: irq_req stays asserted without acknowledge. A one-cycle irq_ack pulse clears it on the next edge.
- R11: Writing a start value of 0 stops the timer: the count reads 0 and no request follows.
- R12: Mode codes 10 and 11 leave the count frozen and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 start value, 2 current count, 3 prescale |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for addr of the previous cycle |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vector | output | 8 | Vector latched when the request was raised |
| irq_ack | input | 1 | Acknowledge pulse that clears the request |

## Verification
The bound checker watches several behaviours on every cycle. It checks that each active tick lowers a count above one by exactly one. It checks that a one-shot count parked at zero stays there. It checks that a request only rises after an expiry event, and that a masked expiry never raises one. It checks that a pending request and its vector hold until acknowledged, and that an acknowledge clears the request. Some behaviours can only be shown by the bench's directed scenarios. These are the exact edge at which expiry lands for each prescale code, the periodic reload interval, and the frozen count in the inactive modes. They also include the status bit's readback and its immunity to writes, and the stop on a zero start value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_START    = 2'd1,
    REG_COUNT    = 2'd2,
    REG_PRESCALE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_FROZEN_A = 2'b10,
    MODE_FROZEN_B = 2'b11
  } run_mode_e;

  // control word field positions (software-visible layout)
  localparam int VEC_LSB  = 0;
  localparam int STAT_BIT = 12;
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = 17;

  // log2 of the divisor selected by a 4-bit prescale code
  function automatic logic [2:0] div_log2(input logic [3:0] code);
    logic [2:0] idx;
    if (code[2]) return 3'd0;
    idx = {code[3], code[1:0]};
    return idx + 3'd1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int MAX_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] log2_div,
  output logic       tick
);
  localparam int PCNT_W = MAX_LOG2;

  logic [PCNT_W-1:0] cnt;
  logic [PCNT_W-1:0] lim;

  always_comb begin
    lim  = PCNT_W'((32'd1 << log2_div) - 32'd1);
    tick = (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PCNT_W'(1);
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] start_val,
  output logic             expire
);
  logic active;

  always_comb begin
    active = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
    expire = active && tick && !load && (cur == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      start_val <= '0;
    end else if (load) begin
      cur       <= load_val;
      start_val <= load_val;
    end else if (active && tick) begin
      if (cur != '0) begin
        cur <= cur - CNT_W'(1);
      end else if (mode == MODE_PERIODIC) begin
        cur <= start_val;
      end
    end
  end
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  input  logic             ack,
  output logic             pending,
  output logic [VEC_W-1:0] vec_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      vec_out <= '0;
    end else if (expire && !mask) begin
      pending <= 1'b1;
      vec_out <= vector;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_tick_timer.sv
module cpu_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int VEC_W    = 8,
  parameter int SEL_W    = 4,
  parameter int MAX_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack
);
  logic [VEC_W-1:0] ctrl_vec;
  logic             ctrl_mask;
  logic [1:0]       ctrl_mode;
  logic [SEL_W-1:0] pre_code;
  logic             load;
  logic             tick;
  logic             exp_evt;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] start_val;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_next;

  assign load = wr_en && (addr == REG_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_vec  <= '0;
      ctrl_mask <= 1'b0;
      ctrl_mode <= MODE_ONESHOT;
      pre_code  <= '0;
    end else if (wr_en) begin
      if (addr == REG_CTRL) begin
        ctrl_vec  <= wdata[VEC_LSB +: VEC_W];
        ctrl_mask <= wdata[MASK_BIT];
        ctrl_mode <= wdata[MODE_LSB +: 2];
      end
      if (addr == REG_PRESCALE) begin
        pre_code <= wdata[SEL_W-1:0];
      end
    end
  end

  tick_prescaler #(.MAX_LOG2(MAX_LOG2)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .restart  (load),
    .log2_div (div_log2(pre_code)),
    .tick     (tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (wdata[CNT_W-1:0]),
    .tick      (tick),
    .mode      (ctrl_mode),
    .cur       (cur_cnt),
    .start_val (start_val),
    .expire    (exp_evt)
  );

  tick_irq_ctrl #(.VEC_W(VEC_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .expire  (exp_evt),
    .mask    (ctrl_mask),
    .vector  (ctrl_vec),
    .ack     (irq_ack),
    .pending (irq_req),
    .vec_out (irq_vector)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[VEC_LSB +: VEC_W] = ctrl_vec;
    ctrl_word[STAT_BIT]         = irq_req;
    ctrl_word[MASK_BIT]         = ctrl_mask;
    ctrl_word[MODE_LSB +: 2]    = ctrl_mode;
    case (addr)
      REG_CTRL:  rd_next = ctrl_word;
      REG_START: rd_next = DATA_W'(start_val);
      REG_COUNT: rd_next = DATA_W'(cur_cnt);
      default:   rd_next = DATA_W'(pre_code);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/cpu_tick_timer_chk.sv
module cpu_tick_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vector,
  input logic [CNT_W-1:0] cur_cnt,
  input logic             tick,
  input logic             exp_evt,
  input logic             load,
  input logic [1:0]       mode,
  input logic             mask
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cur_cnt > CNT_W'(1) && (mode == 2'b00 || mode == 2'b01))
      |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R6
  oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && cur_cnt == '0 && !load) |=> (cur_cnt == '0));

  // R3
  rise_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req ##1 irq_req |-> $past(exp_evt));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_evt && mask && !irq_req) |=> !irq_req);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector)));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !exp_evt) |=> !irq_req);
endmodule

bind cpu_tick_timer cpu_tick_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .cur_cnt    (cur_cnt),
  .tick       (tick),
  .exp_evt    (exp_evt),
  .load       (load),
  .mode       (ctrl_mode),
  .mask       (ctrl_mask)
);

// File: tb/cpu_tick_timer_tb.sv
module cpu_tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;
  logic        irq_ack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_tick_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input logic [7:0] v, input logic m,
                                       input logic [1:0] md, input logic st);
    return 32'(v) | (32'(st) << 12) | (32'(m) << 16) | (32'(md) << 17);
  endfunction

  // at a negedge on entry; consumes one edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_req", 32'(irq_req), 32'd0);
    rd(2'd0, d); check("R1 ctrl", d, 32'd0);
    rd(2'd1, d); check("R1 start", d, 32'd0);
    rd(2'd2, d); check("R1 count", d, 32'd0);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    wr(2'd0, ctrl(8'h41, 1'b0, 2'b00, 1'b0));
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd100);
    addr = 2'd2;
    waitn(11);
    check("R2 count after 10 ticks", rdata, 32'd90);
    rd(2'd1, d); check("R2 start readback", d, 32'd100);
    wr(2'd1, 32'd0);
    rd(2'd2, d); check("R11 count stopped", d, 32'd0);
    waitn(200);
    check("R11 no request", 32'(irq_req), 32'd0);
  endtask

  task automatic t_expiry(input string req, input logic [3:0] code, input int dv);
    wr(2'd0, ctrl(8'h9c, 1'b0, 2'b00, 1'b0));
    wr(2'd3, 32'(code));
    wr(2'd1, 32'd3);
    waitn(3*dv - 1);
    check({req, " before expiry"}, 32'(irq_req), 32'd0);
    waitn(1);
    check({req, " at expiry"}, 32'(irq_req), 32'd1);
    check("R3 vector", 32'(irq_vector), 32'h9c);
    ack();
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(2'd0, ctrl(8'h22, 1'b0, 2'b00, 1'b0));
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd5);
    waitn(5);
    check("R6 first expiry", 32'(irq_req), 32'd1);
    ack();
    check("R10 ack clears", 32'(irq_req), 32'd0);
    waitn(50);
    check("R6 no repeat", 32'(irq_req), 32'd0);
    rd(2'd2, d); check("R6 count parked", d, 32'd0);
  endtask

  task automatic t_periodic();
    wr(2'd0, ctrl(8'h33, 1'b0, 2'b01, 1'b0));
    wr(2'd3, 32'h0);
    wr(2'd1, 32'd4);
    waitn(7);
    check("R7 before first", 32'(irq_req), 32'd0);
    waitn(1);
    check("R7 first", 32'(irq_req), 32'd1);
    ack();
    waitn(8);
    check("R7 before second", 32'(irq_req), 32'd0);
    waitn(1);
    check("R7 second", 32'(irq_req), 32'd1);
    ack();
    wr(2'd1, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd0, ctrl(8'h10, 1'b1, 2'b00, 1'b0));
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd3);
    waitn(8);
    check("R8 masked request", 32'(irq_req), 32'd0);
    rd(2'd0, d);
    check("R8 status stays 0", 32'(d[12]), 32'd0);
    check("R8 mask readback", 32'(d[16]), 32'd1);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(2'd0, ctrl(8'h5a, 1'b0, 2'b00, 1'b1));
    rd(2'd0, d);
    check("R9 status write ignored", d, 32'h0000005a);
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd2);
    waitn(2);
    check("R9 request raised", 32'(irq_req), 32'd1);
    waitn(20);
    check("R10 held without ack", 32'(irq_req), 32'd1);
    rd(2'd0, d);
    check("R9 status pending", 32'(d[12]), 32'd1);
    ack();
    rd(2'd0, d);
    check("R9 status idle after ack", 32'(d[12]), 32'd0);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    wr(2'd0, ctrl(8'h01, 1'b0, 2'b10, 1'b0));
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd10);
    waitn(30);
    check("R12 mode 10 no request", 32'(irq_req), 32'd0);
    rd(2'd2, d); check("R12 mode 10 frozen", d, 32'd10);
    wr(2'd0, ctrl(8'h01, 1'b0, 2'b11, 1'b0));
    waitn(30);
    check("R12 mode 11 no request", 32'(irq_req), 32'd0);
    rd(2'd2, d); check("R12 mode 11 frozen", d, 32'd10);
    wr(2'd1, 32'd0);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst = 1'b0;
    waitn(1);
    t_reset();
    t_countdown();
    t_expiry("R4 div1 1011",   4'b1011, 1);
    t_expiry("R4 div2 0000",   4'b0000, 2);
    t_expiry("R4 div16 0011",  4'b0011, 16);
    t_expiry("R4 div32 1000",  4'b1000, 32);
    t_expiry("R4 div128 1010", 4'b1010, 128);
    t_expiry("R5 code 0100",   4'b0100, 1);
    t_expiry("R5 code 1111",   4'b1111, 1);
    t_oneshot();
    t_periodic();
    t_mask();
    t_status();
    t_frozen();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule